// File: doc/BRIEF.md
# Virtual Thread Spawn Dispatcher

The dispatcher hands out virtual thread numbers from an inclusive range to a fixed pool of execution units. A serial controller issues one spawn command with a lower and an upper bound and then waits. While the dispatcher is in parallel mode, every unit that is free and asks for work receives the next unused number. A unit that completes its thread may ask again in the same cycle it reports completion, so fast units take more threads than slow ones and no static partition is needed.

When the range is used up and no unit still holds a thread, the dispatcher raises a one-cycle join pulse, drops parallel mode and the serial controller resumes. A range whose upper bound lies below its lower bound creates no threads and joins at once.

Top module: `spawn_dispatch`

## Requirements
- R1: A spawn command accepted in serial mode makes `par_o` high on the following cycle. The first number handed out is the lower bound.
- R2: Every number from the lower bound to the upper bound inclusive is granted exactly once per spawn, and no other number is granted.
- R3: A grant (`gnt_o[u]` high for one cycle, with the number on `gnt_id_o[u*ID_W +: ID_W]`) appears on the cycle after unit u requested. A unit that did not request is never granted.
- R4: Units requesting in the same cycle are served by fixed priority. The lowest unit index gets the lowest number, and the numbers are consecutive. Requesters beyond the remaining count are not granted.
- R5: No granted number exceeds the upper bound. This holds also when the upper bound is the largest value that `ID_W` bits can hold.
- R6: A unit that holds a thread is not granted again until it raises `done_i`. It may request in the same cycle as `done_i` and then be granted.
- R7: `join_o` pulses for exactly one cycle once the range is used up and no unit holds a thread. `par_o` falls in that same cycle.
- R8: A spawn with upper bound below lower bound grants nothing. `join_o` pulses on the cycle after `par_o` rose.
- R9: A spawn command that arrives while in parallel mode is ignored, and the running range is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spawn_i | input | 1 | Spawn command strobe |
| low_i | input | ID_W | Lower bound of the range, inclusive |
| high_i | input | ID_W | Upper bound of the range, inclusive |
| req_i | input | N_UNITS | Per-unit work request |
| done_i | input | N_UNITS | Per-unit thread completion |
| gnt_o | output | N_UNITS | Per-unit grant pulse |
| gnt_id_o | output | N_UNITS*ID_W | Per-unit granted thread number, held after the grant |
| par_o | output | 1 | Parallel mode, serial controller paused |
| join_o | output | 1 | One-cycle join pulse |

## Verification
On every cycle, the assertions check the following: grants only follow requests, no number passes the stored upper bound, a held unit is never given a new thread, the stored bounds stay stable through parallel mode, and join is a single pulse that leaves parallel mode with all units free. Only the bench scenarios can show the rest. These are that each number in the range appears exactly once, that simultaneous requesters receive consecutive numbers in index order, that empty and top-of-range spawns behave correctly, and that a spawn issued mid-run leaves the range untouched.

// File: rtl/spawn_dispatch_pkg.sv
package spawn_dispatch_pkg;
  typedef enum logic {MODE_SERIAL, MODE_PARALLEL} mode_e;
endpackage

// File: rtl/sd_alloc.sv
// Fixed-priority allocation of consecutive thread numbers to eligible units.
module sd_alloc #(
  parameter int N_UNITS = 4,
  parameter int ID_W    = 8,
  localparam int CNT_W  = $clog2(N_UNITS + 1),
  localparam int XW     = ID_W + 1
) (
  input  logic [N_UNITS-1:0]         elig_i,
  input  logic [XW-1:0]              next_i,
  input  logic [XW-1:0]              high_i,
  output logic [N_UNITS-1:0]         gnt_o,
  output logic [N_UNITS-1:0][XW-1:0] id_o,
  output logic [CNT_W-1:0]           cnt_o
);
  logic [N_UNITS:0][CNT_W-1:0] rank;
  logic [N_UNITS:0][CNT_W-1:0] taken;

  assign rank[0]  = '0;
  assign taken[0] = '0;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    assign id_o[u]      = next_i + XW'(rank[u]);
    assign gnt_o[u]     = elig_i[u] && (id_o[u] <= high_i);
    assign rank[u+1]    = rank[u] + CNT_W'(elig_i[u]);
    assign taken[u+1]   = taken[u] + CNT_W'(gnt_o[u]);
  end

  assign cnt_o = taken[N_UNITS];
endmodule

// File: rtl/sd_units.sv
// Per-unit occupancy: set on grant, cleared on completion.
module sd_units #(
  parameter int N_UNITS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] set_i,
  input  logic [N_UNITS-1:0] done_i,
  output logic [N_UNITS-1:0] busy_o
);
  logic [N_UNITS-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~done_i) | set_i;
  end

  assign busy_o = busy_q;

  p_no_regrant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & busy_q & ~done_i) == '0)
    else $error("R6: held unit granted again");
endmodule

// File: rtl/sd_ctrl.sv
// Serial/parallel mode, range bounds, next number and join generation.
module sd_ctrl
  import spawn_dispatch_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int CNT_W   = 3,
  localparam int XW     = ID_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            spawn_i,
  input  logic [ID_W-1:0] low_i,
  input  logic [ID_W-1:0] high_i,
  input  logic [CNT_W-1:0] adv_i,
  input  logic            any_busy_i,
  output logic            par_o,
  output logic            join_o,
  output logic [XW-1:0]   next_o,
  output logic [XW-1:0]   high_o
);
  mode_e         mode_q;
  logic          join_q;
  logic [XW-1:0] next_q, hi_q;
  logic          exhausted;

  assign exhausted = next_q > hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SERIAL;
      join_q <= 1'b0;
      next_q <= '0;
      hi_q   <= '0;
    end else begin
      join_q <= 1'b0;
      unique case (mode_q)
        MODE_SERIAL: if (spawn_i) begin
          mode_q <= MODE_PARALLEL;
          next_q <= {1'b0, low_i};
          hi_q   <= {1'b0, high_i};
        end
        MODE_PARALLEL: begin
          next_q <= next_q + XW'(adv_i);
          if (exhausted && !any_busy_i) begin
            join_q <= 1'b1;
            mode_q <= MODE_SERIAL;
          end
        end
        default: mode_q <= MODE_SERIAL;
      endcase
    end
  end

  assign par_o  = (mode_q == MODE_PARALLEL);
  assign join_o = join_q;
  assign next_o = next_q;
  assign high_o = hi_q;

  p_bounds_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_o && $past(par_o)) |-> ($stable(hi_q) && next_q >= $past(next_q)))
    else $error("R9: range changed during parallel mode");

  p_join_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_o |=> !join_o)
    else $error("R7: join longer than one cycle");

  p_join_serial_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_o |-> (!par_o && !$past(any_busy_i)))
    else $error("R7: join while parallel or busy");
endmodule

// File: rtl/spawn_dispatch.sv
module spawn_dispatch
  import spawn_dispatch_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int ID_W    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    spawn_i,
  input  logic [ID_W-1:0]         low_i,
  input  logic [ID_W-1:0]         high_i,
  input  logic [N_UNITS-1:0]      req_i,
  input  logic [N_UNITS-1:0]      done_i,
  output logic [N_UNITS-1:0]      gnt_o,
  output logic [N_UNITS*ID_W-1:0] gnt_id_o,
  output logic                    par_o,
  output logic                    join_o
);
  localparam int CNT_W = $clog2(N_UNITS + 1);
  localparam int XW    = ID_W + 1;

  logic [N_UNITS-1:0]         busy, elig, gnt_c, gnt_q;
  logic [N_UNITS-1:0][XW-1:0] id_c;
  logic [N_UNITS-1:0][ID_W-1:0] id_q;
  logic [CNT_W-1:0]           adv;
  logic [XW-1:0]              next_id, hi_id;
  logic                       par;

  // a unit finishing this cycle may take new work immediately
  assign elig = req_i & (~busy | done_i) & {N_UNITS{par}};

  sd_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .spawn_i, .low_i, .high_i,
    .adv_i(adv), .any_busy_i(|busy),
    .par_o(par), .join_o, .next_o(next_id), .high_o(hi_id)
  );

  sd_alloc #(.N_UNITS(N_UNITS), .ID_W(ID_W)) u_alloc (
    .elig_i(elig), .next_i(next_id), .high_i(hi_id),
    .gnt_o(gnt_c), .id_o(id_c), .cnt_o(adv)
  );

  sd_units #(.N_UNITS(N_UNITS)) u_units (
    .clk_i, .rst_ni, .set_i(gnt_c), .done_i, .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      id_q  <= '0;
    end else begin
      gnt_q <= gnt_c;
      for (int u = 0; u < N_UNITS; u++)
        if (gnt_c[u]) id_q[u] <= id_c[u][ID_W-1:0];
    end
  end

  assign gnt_o = gnt_q;
  assign par_o = par;
  for (genvar u = 0; u < N_UNITS; u++) begin : g_out
    assign gnt_id_o[u*ID_W +: ID_W] = id_q[u];

    p_gnt_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[u] |-> $past(req_i[u]))
      else $error("R3: grant without request");

    p_id_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[u] |-> ({1'b0, id_q[u]} <= hi_id))
      else $error("R5: number above upper bound");
  end
endmodule

// File: tb/tb_spawn_dispatch.sv
module tb_spawn_dispatch;
  localparam int N  = 4;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spawn_i = 1'b0;
  logic [IW-1:0] low_i = '0, high_i = '0;
  logic [N-1:0] req_i = '0, done_i = '0;
  logic [N-1:0] gnt_o;
  logic [N*IW-1:0] gnt_id_o;
  logic par_o, join_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  spawn_dispatch #(.N_UNITS(N), .ID_W(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .spawn_i, .low_i, .high_i,
    .req_i, .done_i, .gnt_o, .gnt_id_o, .par_o, .join_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #1_200_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // units hold a thread for u+1 cycles; unit 3 keeps requesting while busy
  task automatic run_spawn(input int lo, input int hi, input bit poke);
    bit seen [256];
    bit busy_m [N];
    int rem [N];
    int cnt, got;
    bit first_seen, joined;
    cnt = (hi >= lo) ? hi - lo + 1 : 0;
    got = 0; first_seen = 0; joined = 0;
    foreach (seen[i]) seen[i] = 0;
    for (int u = 0; u < N; u++) begin busy_m[u] = 0; rem[u] = 0; end

    @(negedge clk);
    spawn_i = 1'b1; low_i = IW'(lo); high_i = IW'(hi);
    req_i = '1; done_i = '0;
    @(negedge clk);
    spawn_i = 1'b0;
    chk(par_o == 1'b1, "R1 par_o after spawn", par_o, 1);
    chk(gnt_o == '0, "R3 no grant on spawn cycle", gnt_o, 0);

    for (int cyc = 1; cyc < 400; cyc++) begin
      bit just [N];
      @(negedge clk);
      if (poke && cyc == 3) begin
        spawn_i = 1'b1; low_i = 8'd0; high_i = 8'd250;
      end else begin
        spawn_i = 1'b0; low_i = IW'(lo); high_i = IW'(hi);
      end
      if (!first_seen && (gnt_o != '0 || join_o)) begin
        first_seen = 1;
        if (cnt > 0) begin
          chk(cyc == 1, "R4 first grant cycle", cyc, 1);
          for (int u = 0; u < N; u++) begin
            chk(gnt_o[u] == (u < cnt), "R4 grant pattern", gnt_o[u], (u < cnt));
            if (u < cnt)
              chk(int'(gnt_id_o[u*IW +: IW]) == lo + u, "R1 R4 consecutive number",
                  gnt_id_o[u*IW +: IW], lo + u);
          end
        end
      end
      for (int u = 0; u < N; u++) begin
        just[u] = 0;
        if (gnt_o[u]) begin
          int id;
          id = int'(gnt_id_o[u*IW +: IW]);
          chk(id >= lo && id <= hi, "R5 number within range", id, hi);
          chk(!seen[id], "R2 number unique", id, -1);
          chk(!busy_m[u], "R6 held unit regranted", u, -1);
          seen[id] = 1; got++;
          busy_m[u] = 1; rem[u] = u + 1; just[u] = 1;
        end
      end
      if (poke && cyc == 5)
        chk(par_o == 1'b1, "R9 still parallel after spawn poke", par_o, 1);
      if (join_o) begin
        int nb;
        nb = 0;
        for (int u = 0; u < N; u++) nb += busy_m[u];
        chk(nb == 0, "R7 join with all units free", nb, 0);
        chk(got == cnt, "R2 grant total at join", got, cnt);
        chk(par_o == 1'b0, "R7 par_o falls with join", par_o, 0);
        if (cnt == 0) chk(cyc == 1, "R8 empty range joins at once", cyc, 1);
        joined = 1;
        req_i = '0; done_i = '0;
        break;
      end
      for (int u = 0; u < N; u++) begin
        done_i[u] = 1'b0;
        if (busy_m[u] && !just[u]) begin
          rem[u]--;
          if (rem[u] == 0) begin done_i[u] = 1'b1; busy_m[u] = 0; end
        end
        req_i[u] = !busy_m[u] || (u == N - 1);
      end
    end
    chk(joined, "R7 join reached", joined, 1);
    @(negedge clk);
    chk(join_o == 1'b0, "R7 join single cycle", join_o, 0);
    chk(gnt_o == '0, "R2 no grant after join", gnt_o, 0);
    for (int i = 0; i < 256; i++)
      if ((i >= lo && i <= hi) != seen[i])
        chk(0, "R2 coverage of range", seen[i], (i >= lo && i <= hi));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gnt_o == '0 && !par_o && !join_o, "R1 reset state", {gnt_o, par_o, join_o}, 0);
    rst_n = 1'b1;
    for (int c = 0; c <= 11; c++)
      run_spawn(10 + 3 * c, 10 + 3 * c + c - 1, 1'b0);
    run_spawn(20, 12, 1'b0);      // R8 high below low
    run_spawn(40, 49, 1'b1);      // R9 spawn during parallel mode
    run_spawn(253, 255, 1'b0);    // R5 top of number space
    run_spawn(255, 255, 1'b0);
    run_spawn(0, 0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule